// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block drives the control strobes of a multiplexed external memory bus: an 8-bit shared address/data lane, a separate upper-address byte, an address-latch strobe, an active-low code-fetch strobe and active-low data read and write strobes. One clock period of the block is one oscillator period. The block runs back-to-back bus slots. A basic slot lasts six periods. An external data slot lasts twelve periods, and the second latch pulse inside it is left out.

The core presents one command at a time on `req`, with its address and write data. The block samples the command in the last period of the current slot, which it marks with `req_take`, and runs that command as the next slot. In an internal slot (`req` = none) no strobe moves except the address latch. Fetched or read bytes come back on `rdata` with a one-period `rdata_valid` pulse.

A small special-register port holds a quiet bit. While that bit is set, internal slots keep the latch strobe low. External slots still pulse it. The bit is sampled once per slot, at the slot boundary.

State machine: the states are `ST_INT` (internal, 6 periods), `ST_CODE` (code fetch, 6 periods), `ST_DRD` (data read, 12 periods) and `ST_DWR` (data write, 12 periods). A counter `tick` counts periods within the current slot. Every state moves on its last tick to the state picked by the sampled command:
- none goes to `ST_INT`
- fetch goes to `ST_CODE`
- read goes to `ST_DRD`
- write goes to `ST_DWR`

Reset enters `ST_INT` at tick 0.

Top module: `extbus_sequencer`

## Requirements
- R1: While `rst` is high, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `ad_oe` is 0 and `rdata_valid` is 0. The quiet bit resets to 0, so the first internal slot after reset pulses `ale`.
- R2: In an internal slot with the quiet bit clear, `ale` is high in ticks 0 and 1 of every 6-period slot and low otherwise, which gives one sixth of the clock rate. No other strobe is active.
- R3: A fetch slot (`req` = 1) drives address bits [7:0] on `ad_out` with `ad_oe` high in ticks 0–1, with `ale` high. It releases the lane from tick 2. `psen_n` is low in ticks 3–5. `ad_in` is sampled at the end of tick 5, and `rdata` with `rdata_valid` appears in tick 0 of the following slot.
- R4: A read slot (`req` = 2) lasts 12 periods with a single `ale` pulse in ticks 0–1. `rd_n` is low in ticks 5–10, which is 3 periods after `ale` falls, for 6 periods. `ad_in` is sampled at the end of tick 10, and `rdata_valid` is high in tick 11.
- R5: A write slot (`req` = 3) lasts 12 periods with one `ale` pulse. `wr_n` is low in ticks 5–10. The write byte is driven on `ad_out` with `ad_oe` high in ticks 2–11, so it is set up 3 periods before `wr_n` falls and held 1 period after it rises.
- R6: `addr_hi` shows address bits [15:8] of the most recent external command and stays stable for the whole external slot.
- R7: A special-register write to address 8Eh sets the quiet bit from data bit 0. With the bit set, `ale` stays low in internal slots and still pulses in fetch, read and write slots. A write to any other address leaves the bit unchanged.
- R8: `req_take` is high exactly in the last period of each slot. The command is sampled only at that edge, and values on `req` at other times have no effect.
- R9: At most one of `psen_n`, `rd_n`, `wr_n` is low at a time, and `ad_oe` is low whenever `psen_n` or `rd_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 2 | Next command: 0 none, 1 fetch, 2 read, 3 write |
| req_addr | input | 16 | Address of the next command |
| req_wdata | input | 8 | Write byte of the next command |
| req_take | output | 1 | High in the period whose closing edge samples `req` |
| sfr_we | input | 1 | Special-register write strobe |
| sfr_addr | input | 8 | Special-register write address |
| sfr_wdata | input | 8 | Special-register write data |
| ad_in | input | 8 | Shared lane, incoming value |
| ad_out | output | 8 | Shared lane, outgoing value |
| ad_oe | output | 1 | Shared lane output enable |
| addr_hi | output | 8 | Upper address byte |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Code-fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| rdata | output | 8 | Byte captured from the lane |
| rdata_valid | output | 1 | One-period pulse marking a new `rdata` |

## Verification
A wrong state or tick value shows up in the first period where the strobe pattern of the wrong slot differs from the right one. That happens within two periods for `ale`, or within the same period for `req_take`, because every output is decoded straight from the state and tick registers. A wrong slot length moves `req_take` and every following strobe, so one slot after the fault the bench sees it on every port. A stale captured address or quiet bit is visible on `addr_hi`, `ad_out` or `ale` in tick 0 or 1 of the slot that uses it.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

    typedef enum logic [1:0] {
        REQ_NONE  = 2'd0,
        REQ_FETCH = 2'd1,
        REQ_READ  = 2'd2,
        REQ_WRITE = 2'd3
    } req_e;

    typedef enum logic [1:0] {
        ST_INT,
        ST_CODE,
        ST_DRD,
        ST_DWR
    } slot_e;

    // slot timing, in oscillator periods
    localparam int SLOT_LEN  = 6;
    localparam int DATA_LEN  = 2 * SLOT_LEN;
    localparam int LATCH_LEN = 2;
    localparam int PS_GAP    = 1;
    localparam int PS_LEN    = 3;
    localparam int DS_GAP    = 3;
    localparam int DS_LEN    = 6;
    localparam int TICK_W    = $clog2(DATA_LEN);

    localparam logic [TICK_W-1:0] T_LATCH = TICK_W'(LATCH_LEN);
    localparam logic [TICK_W-1:0] T_PS0   = TICK_W'(LATCH_LEN + PS_GAP);
    localparam logic [TICK_W-1:0] T_PS1   = TICK_W'(LATCH_LEN + PS_GAP + PS_LEN - 1);
    localparam logic [TICK_W-1:0] T_DS0   = TICK_W'(LATCH_LEN + DS_GAP);
    localparam logic [TICK_W-1:0] T_DS1   = TICK_W'(LATCH_LEN + DS_GAP + DS_LEN - 1);
    localparam logic [TICK_W-1:0] LAST_S  = TICK_W'(SLOT_LEN - 1);
    localparam logic [TICK_W-1:0] LAST_D  = TICK_W'(DATA_LEN - 1);

endpackage

// File: rtl/xb_aux_reg.sv
module xb_aux_reg #(
    parameter logic [7:0] AUX_ADDR = 8'h8E,
    parameter int         QUIET_BIT = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sfr_we,
    input  logic [7:0] sfr_addr,
    input  logic [7:0] sfr_wdata,
    output logic       quiet
);

    always_ff @(posedge clk) begin
        if (rst)
            quiet <= 1'b0;
        else if (sfr_we && sfr_addr == AUX_ADDR)
            quiet <= sfr_wdata[QUIET_BIT];
    end

    // R7: writes to other addresses do not touch the bit
    a_r7_other_addr: assert property (@(posedge clk) disable iff (rst)
        (sfr_we && sfr_addr != AUX_ADDR) |=> $stable(quiet));

endmodule

// File: rtl/xb_slot_fsm.sv
module xb_slot_fsm
    import extbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          req,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                quiet,
    output slot_e               state,
    output logic [TICK_W-1:0]   tick,
    output logic                slot_quiet,
    output logic [ADDR_W-1:0]   addr_q,
    output logic [DATA_W-1:0]   wdata_q,
    output logic                take
);

    slot_e             nxt;
    logic [TICK_W-1:0] last;
    req_e              cmd;

    assign cmd = req_e'(req);

    always_comb begin
        last = (state == ST_DRD || state == ST_DWR) ? LAST_D : LAST_S;
        take = (tick == last);
        unique case (cmd)
            REQ_FETCH: nxt = ST_CODE;
            REQ_READ:  nxt = ST_DRD;
            REQ_WRITE: nxt = ST_DWR;
            default:   nxt = ST_INT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_INT;
            tick       <= '0;
            slot_quiet <= 1'b0;
            addr_q     <= '0;
            wdata_q    <= '0;
        end else if (take) begin
            state      <= nxt;
            tick       <= '0;
            slot_quiet <= quiet;
            if (cmd != REQ_NONE)
                addr_q <= req_addr;
            if (cmd == REQ_WRITE)
                wdata_q <= req_wdata;
        end else begin
            tick <= tick + 1'b1;
        end
    end

    // R8: each slot ends in the tick after take and restarts at 0
    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        take |=> (tick == '0));
    a_r8_tick_bound: assert property (@(posedge clk) disable iff (rst)
        tick <= LAST_D);
    // R6: address held for the whole slot
    a_r6_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(addr_q));

endmodule

// File: rtl/xb_strobe_gen.sv
module xb_strobe_gen
    import extbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  slot_e               state,
    input  logic [TICK_W-1:0]   tick,
    input  logic                slot_quiet,
    input  logic [ADDR_W-1:0]   addr_q,
    input  logic [DATA_W-1:0]   wdata_q,
    output logic                ale,
    output logic                psen_n,
    output logic                rd_n,
    output logic                wr_n,
    output logic                ad_oe,
    output logic [DATA_W-1:0]   ad_out,
    output logic [ADDR_W-9:0]   addr_hi
);

    logic in_latch;

    always_comb begin
        in_latch = (tick < T_LATCH);
        ale      = 1'b0;
        psen_n   = 1'b1;
        rd_n     = 1'b1;
        wr_n     = 1'b1;
        ad_oe    = 1'b0;
        unique case (state)
            ST_INT: begin
                ale = !rst && in_latch && !slot_quiet;
            end
            ST_CODE: begin
                ale    = !rst && in_latch;
                ad_oe  = in_latch;
                psen_n = !(tick >= T_PS0 && tick <= T_PS1);
            end
            ST_DRD: begin
                ale   = !rst && in_latch;
                ad_oe = in_latch;
                rd_n  = !(tick >= T_DS0 && tick <= T_DS1);
            end
            ST_DWR: begin
                ale   = !rst && in_latch;
                ad_oe = 1'b1;
                wr_n  = !(tick >= T_DS0 && tick <= T_DS1);
            end
            default: ;
        endcase
        ad_out  = in_latch ? addr_q[DATA_W-1:0] : wdata_q;
        addr_hi = addr_q[ADDR_W-1:8];
    end

    // R9: strobes exclusive, lane free while a device drives it
    a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);
    a_r9_lane_free: assert property (@(posedge clk) disable iff (rst)
        (!psen_n || !rd_n) |-> !ad_oe);
    // R2: latch pulse lasts exactly two periods
    a_r2_ale_min: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |=> ale);
    a_r2_ale_max: assert property (@(posedge clk) disable iff (rst)
        (ale && $past(ale)) |=> !ale);
    // R5: write byte around the write strobe
    a_r5_wr_setup: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_n) |-> ($past(ad_oe) && ad_oe));
    a_r5_wr_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> ad_oe);

endmodule

// File: rtl/xb_rd_capture.sv
module xb_rd_capture
    import extbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  slot_e               state,
    input  logic [TICK_W-1:0]   tick,
    input  logic [DATA_W-1:0]   ad_in,
    output logic [DATA_W-1:0]   rdata,
    output logic                rdata_valid
);

    logic cap;

    always_comb
        cap = (state == ST_CODE && tick == T_PS1) ||
              (state == ST_DRD  && tick == T_DS1);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= cap;
            if (cap)
                rdata <= ad_in;
        end
    end

    // R3: valid is a single-period pulse
    a_r3_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |=> !rdata_valid);

endmodule

// File: rtl/extbus_sequencer.sv
module extbus_sequencer
    import extbus_pkg::*;
#(
    parameter int         ADDR_W   = 16,
    parameter int         DATA_W   = 8,
    parameter logic [7:0] AUX_ADDR = 8'h8E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_take,
    input  logic              sfr_we,
    input  logic [7:0]        sfr_addr,
    input  logic [7:0]        sfr_wdata,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-9:0] addr_hi,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);

    slot_e             state;
    logic [TICK_W-1:0] tick;
    logic              quiet;
    logic              slot_quiet;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    xb_aux_reg #(.AUX_ADDR(AUX_ADDR), .QUIET_BIT(0)) u_aux (
        .clk(clk), .rst(rst), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .quiet(quiet)
    );

    xb_slot_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst(rst), .req(req), .req_addr(req_addr),
        .req_wdata(req_wdata), .quiet(quiet), .state(state), .tick(tick),
        .slot_quiet(slot_quiet), .addr_q(addr_q), .wdata_q(wdata_q),
        .take(req_take)
    );

    xb_strobe_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stb (
        .clk(clk), .rst(rst), .state(state), .tick(tick),
        .slot_quiet(slot_quiet), .addr_q(addr_q), .wdata_q(wdata_q),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .ad_oe(ad_oe), .ad_out(ad_out), .addr_hi(addr_hi)
    );

    xb_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst(rst), .state(state), .tick(tick), .ad_in(ad_in),
        .rdata(rdata), .rdata_valid(rdata_valid)
    );

    // R1: nothing driven or strobed in reset
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |-> (!ale && psen_n && rd_n && wr_n && !ad_oe));

endmodule

// File: tb/sim_extbus_sequencer.sv
`timescale 1ns/1ps
module sim_extbus_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  req = 2'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        req_take;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_addr = 8'h0;
    logic [7:0]  sfr_wdata = 8'h0;
    logic [7:0]  ad_in = 8'h0;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  addr_hi;
    logic        ale, psen_n, rd_n, wr_n;
    logic [7:0]  rdata;
    logic        rdata_valid;

    int errors = 0;
    int checks = 0;

    // model of the slot now running
    logic [1:0]  cur_k = 2'd0;
    logic [15:0] cur_a = 16'h0;
    logic [7:0]  cur_w = 8'h0;
    logic [7:0]  cur_d = 8'h0;
    bit          cur_q = 1'b0;
    logic [1:0]  prev_k = 2'd0;
    logic [7:0]  prev_d = 8'h0;
    logic [7:0]  last_hi = 8'h0;
    bit          quiet_m = 1'b0;

    always #2 clk = ~clk;

    extbus_sequencer u0 (
        .clk(clk), .rst(rst), .req(req), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_take(req_take), .sfr_we(sfr_we),
        .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi), .ale(ale),
        .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata),
        .rdata_valid(rdata_valid)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_slot(input logic [1:0] nk, input logic [15:0] na,
                            input logic [7:0] nw, input logic [7:0] nd,
                            input bit aw, input logic [7:0] aa, input logic [7:0] adt);
        int    len;
        string tag;
        len = (cur_k >= 2'd2) ? 12 : 6;
        case (cur_k)
            2'd0: tag = cur_q ? "R7" : "R2";
            2'd1: tag = "R3";
            2'd2: tag = "R4";
            default: tag = "R5";
        endcase
        for (int k = 0; k < len; k++) begin
            logic [5:0] act_v, exp_v;
            bit e_ale, e_ps, e_rd, e_wr, e_oe, e_tk, e_val;
            @(negedge clk);
            if (k == 0) begin
                ad_in = cur_d;
                req = ~nk;               // junk, must be ignored (R8)
                req_addr = ~na;
                req_wdata = ~nw;
                if (aw) begin
                    sfr_we = 1'b1; sfr_addr = aa; sfr_wdata = adt;
                    if (aa == 8'h8E) quiet_m = adt[0];
                end
            end
            if (k == 1) sfr_we = 1'b0;
            if (k == len - 1) begin
                req = nk; req_addr = na; req_wdata = nw;
            end
            e_ale = (k < 2) && !(cur_k == 2'd0 && cur_q);
            e_ps  = !(cur_k == 2'd1 && k >= 3 && k <= 5);
            e_rd  = !(cur_k == 2'd2 && k >= 5 && k <= 10);
            e_wr  = !(cur_k == 2'd3 && k >= 5 && k <= 10);
            e_oe  = (cur_k != 2'd0 && k < 2) || (cur_k == 2'd3 && k >= 2);
            e_tk  = (k == len - 1);
            act_v = {ale, psen_n, rd_n, wr_n, ad_oe, req_take};
            exp_v = {e_ale, e_ps, e_rd, e_wr, e_oe, e_tk};
            chk(act_v == exp_v, tag, "strobes{ale,psen,rd,wr,oe,take}(R8)",
                32'(act_v), 32'(exp_v));
            if (e_oe)
                chk(ad_out == ((k < 2) ? cur_a[7:0] : cur_w), tag, "ad_out",
                    32'(ad_out), 32'((k < 2) ? cur_a[7:0] : cur_w));
            if (cur_k != 2'd0)
                chk(addr_hi == cur_a[15:8], "R6", "addr_hi",
                    32'(addr_hi), 32'(cur_a[15:8]));
            chk(!((!psen_n || !rd_n) && ad_oe), "R9", "lane free",
                32'({psen_n, rd_n, ad_oe}), 32'h6);
            e_val = (k == 0 && prev_k == 2'd1) || (cur_k == 2'd2 && k == 11);
            chk(rdata_valid == e_val, (cur_k == 2'd2) ? "R4" : "R3",
                "rdata_valid", 32'(rdata_valid), 32'(e_val));
            if (e_val)
                chk(rdata == ((k == 0) ? prev_d : cur_d),
                    (cur_k == 2'd2) ? "R4" : "R3", "rdata",
                    32'(rdata), 32'((k == 0) ? prev_d : cur_d));
        end
        prev_k = cur_k; prev_d = cur_d;
        cur_k = nk; cur_a = na; cur_w = nw; cur_d = nd; cur_q = quiet_m;
        if (nk != 2'd0) last_hi = na[15:8];
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(!ale && psen_n && rd_n && wr_n && !ad_oe && !rdata_valid, "R1",
            "reset idle", 32'({ale, psen_n, rd_n, wr_n, ad_oe, rdata_valid}),
            32'b011100);
        @(posedge clk); #1 rst = 1'b0;
        // first internal slot pulses ale (R1), then fixed cases
        run_slot(2'd1, 16'h1234, 8'h00, 8'h5A, 1'b0, 8'h0, 8'h0);
        run_slot(2'd2, 16'hABCD, 8'h00, 8'hC6, 1'b0, 8'h0, 8'h0);
        run_slot(2'd3, 16'h5A3C, 8'hC3, 8'h00, 1'b0, 8'h0, 8'h0);
        run_slot(2'd0, 16'h0000, 8'h00, 8'h00, 1'b0, 8'h0, 8'h0);
        // R7: write to another address is ignored
        run_slot(2'd0, 16'h0000, 8'h00, 8'h00, 1'b1, 8'h8F, 8'h01);
        run_slot(2'd0, 16'h0000, 8'h00, 8'h00, 1'b0, 8'h0, 8'h0);
        // near-exhaustive pair sweep with the quiet bit clear and set
        for (int m = 0; m < 2; m++) begin
            run_slot(2'd0, 16'h0, 8'h0, 8'h0, 1'b1, 8'h8E, 8'(m) | 8'hFE ^ 8'hFE);
            run_slot(2'd0, 16'h0, 8'h0, 8'h0, 1'b0, 8'h0, 8'h0);
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    int idx;
                    idx = m * 16 + a * 4 + b;
                    run_slot(2'(a), 16'(idx * 16'h2F1B) ^ 16'hA5C3,
                             8'(idx * 37), 8'(idx * 53 + 9), 1'b0, 8'h0, 8'h0);
                    run_slot(2'(b), 16'(idx * 16'h1D07) ^ 16'h3C96,
                             8'(idx * 29 + 1), 8'(idx * 71 + 3), 1'b0, 8'h0, 8'h0);
                end
            end
        end
        run_slot(2'd0, 16'h0, 8'h0, 8'h0, 1'b1, 8'h8E, 8'hFE);
        run_slot(2'd0, 16'h0, 8'h0, 8'h0, 1'b0, 8'h0, 8'h0);
        run_slot(2'd0, 16'h0, 8'h0, 8'h0, 1'b0, 8'h0, 8'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule